// File: doc/BRIEF.md
# Three-Tap Pipelined FIR Filter

This block filters a stream of 32-bit samples with a three-tap finite impulse response. Each output is the weighted sum of the newest accepted sample and the two accepted before it, using three 32-bit coefficient inputs: the newest sample is weighted by `coefA`, the one before it by `coefB`, and the oldest by `coefC`. All products and sums wrap modulo 2^32. A sample counts only in a cycle where its valid strobe is high. The two-entry history advances only on such cycles, so idle gaps in the stream do not change the result.

The logic is split into register layers so that no register-to-register path holds both a multiplier and an adder. The first layer registers each of the three products on its own. The second layer adds the first two products and passes the third along. The third layer adds the partial sum to the delayed third product and drives the output. A valid bit travels next to the data, so the output strobe marks exactly one result per accepted sample, three cycles after it. A control module turns that valid pipeline into per-stage load strobes for the datapath. Any stage without fresh data keeps its contents.

Top module: `fir3_pipe`

## Requirements
- R1: While `rstN` is low, and after it rises until the first result, `outValid` is 0 and `yOut` is 0. Reset empties the sample history, so the first sample after reset sees zero history.
- R2: For an accepted sample x[n], the result is coefA·x[n] + coefB·x[n-1] + coefC·x[n-2]. Here x[n-1] and x[n-2] are the two previously accepted samples.
- R3: A sample accepted at rising edge k has its result visible with `outValid` high after edge k+2, which is three cycles after it was presented. `outValid` is high in exactly those cycles.
- R4: Cycles with `inValid` low do not advance the history. Whatever `sampleIn` holds in such a cycle has no effect on any later result.
- R5: Every multiply and add keeps only the low 32 bits of its result, so the output wraps modulo 2^32.
- R6: In every cycle where `outValid` is low, `yOut` keeps the value of the last result.
- R7: After reset, the first three accepted samples see zero-valued missing history. An impulse of 1 therefore yields coefA, coefB and coefC in turn.
- R8: The coefficients applied to a sample are those present at the rising edge that accepts it. Later coefficient changes do not alter that sample's result.
- R9: Samples accepted on consecutive edges produce results on consecutive cycles, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | High when `sampleIn` carries a sample to accept |
| sampleIn | input | 32 | Input sample |
| coefA | input | 32 | Weight for the newest sample |
| coefB | input | 32 | Weight for the previous sample |
| coefC | input | 32 | Weight for the sample two back |
| outValid | output | 1 | High when `yOut` carries a new result |
| yOut | output | 32 | Filter result, held between results |

## Verification
A corrupted history register goes unnoticed on the first output that follows. It shows in the second or third result after the corrupting cycle, through the coefB or coefC term. Impulse and gap-filled sequences are used so that each history slot alone decides one result. A fault in the valid pipeline or in the stage strobes shows within three cycles: `outValid` lands on the wrong cycle, or `yOut` moves while `outValid` is low. Both are checked on every cycle. Wraparound and coefficient-timing faults appear directly on the first affected result.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

  // Number of filter taps; the adder layers below are arranged for three.
  localparam int NUM_TAPS = 3;
  // Register layers between accepted sample and visible result.
  localparam int PIPE_STAGES = 3;

  // Load strobes sent from the control module to the datapath.
  typedef struct packed {
    logic shiftHist;  // advance the sample history
    logic loadProd;   // capture the three products
    logic loadSum;    // capture the first partial sum and delayed product
    logic loadOut;    // capture the final result
  } stageCtl_t;

endpackage

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
  import fir3_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);

  logic [PIPE_STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_STAGES-2:0], inValid};
    end
  end

  always_comb begin
    ctl.shiftHist = inValid;
    ctl.loadProd  = inValid;
    ctl.loadSum   = validPipe[0];
    ctl.loadOut   = validPipe[1];
  end

  assign outValid = validPipe[PIPE_STAGES-1];

  // Edges since reset release, saturating; keeps $past inside the run.
  logic [1:0] upCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCount <= '0;
    end else if (upCount != 2'd3) begin
      upCount <= upCount + 2'd1;
    end
  end

  // R3: the output strobe follows the input strobe by three cycles.
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (upCount == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R9: back-to-back samples keep the final load strobe high on back-to-back cycles.
  assert_throughput_R9: assert property (@(posedge clk) disable iff (!rstN)
    (upCount == 2'd3 && $past(inValid, 2) && $past(inValid, 3)) |-> (ctl.loadOut && outValid));

endmodule

// File: rtl/fir3_datapath.sv
module fir3_datapath
  import fir3_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  stageCtl_t                         ctl,
  input  logic [DATA_W-1:0]                 sampleIn,
  input  logic [NUM_TAPS-1:0][DATA_W-1:0]   coefs,
  output logic [DATA_W-1:0]                 yOut
);

  localparam int HIST_D = NUM_TAPS - 1;

  // History registers: histReg[0] is one sample back, histReg[1] two back.
  logic [HIST_D-1:0][DATA_W-1:0]   histReg;
  // Operand view: tap 0 is the live sample, tap i the sample i back.
  logic [NUM_TAPS-1:0][DATA_W-1:0] tapView;
  logic [NUM_TAPS-1:0][DATA_W-1:0] prodReg;
  logic [DATA_W-1:0]               partSum;
  logic [DATA_W-1:0]               lastProdDly;
  logic [DATA_W-1:0]               resultReg;

  assign tapView[0] = sampleIn;

  genvar gi;
  generate
    for (gi = 0; gi < HIST_D; gi++) begin : g_hist
      assign tapView[gi+1] = histReg[gi];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          histReg[gi] <= '0;
        end else if (ctl.shiftHist) begin
          histReg[gi] <= tapView[gi];
        end
      end
    end

    // Layer 1: one multiplier per register path.
    for (gi = 0; gi < NUM_TAPS; gi++) begin : g_prod
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prodReg[gi] <= '0;
        end else if (ctl.loadProd) begin
          prodReg[gi] <= coefs[gi] * tapView[gi];
        end
      end
    end
  endgenerate

  // Layer 2: one adder, third product carried alongside.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partSum     <= '0;
      lastProdDly <= '0;
    end else if (ctl.loadSum) begin
      partSum     <= prodReg[0] + prodReg[1];
      lastProdDly <= prodReg[2];
    end
  end

  // Layer 3: one adder into the output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (ctl.loadOut) begin
      resultReg <= partSum + lastProdDly;
    end
  end

  assign yOut = resultReg;

  // R4: history is untouched when no sample is accepted.
  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftHist |=> $stable(histReg));

  // R6: the output register holds whenever its load strobe is low.
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadOut |=> $stable(yOut));

  // R8: the newest-tap product uses the coefficient and sample at the accepting edge.
  assert_prod_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadProd |=> (prodReg[0] == DATA_W'($past(coefs[0]) * $past(sampleIn))));

endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe
  import fir3_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] coefA,
  input  logic [DATA_W-1:0] coefB,
  input  logic [DATA_W-1:0] coefC,
  output logic              outValid,
  output logic [DATA_W-1:0] yOut
);

  stageCtl_t                       ctl;
  logic [NUM_TAPS-1:0][DATA_W-1:0] coefs;

  assign coefs[0] = coefA;
  assign coefs[1] = coefB;
  assign coefs[2] = coefC;

  fir3_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  fir3_datapath #(
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sampleIn (sampleIn),
    .coefs    (coefs),
    .yOut     (yOut)
  );

endmodule

// File: tb/fir3_pipe_tb.sv
module fir3_pipe_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] sampleIn = '0;
  logic [31:0] coefA = '0;
  logic [31:0] coefB = '0;
  logic [31:0] coefC = '0;
  logic        outValid;
  logic [31:0] yOut;

  int checks = 0;
  int fails = 0;

  // Requirement model: history of accepted samples and expected-result delay.
  logic [31:0] h1, h2;
  logic [2:0]  expV;
  logic [31:0] expY [3];
  logic [31:0] lastY;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir3_pipe u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sampleIn (sampleIn),
    .coefA    (coefA),
    .coefB    (coefB),
    .coefC    (coefC),
    .outValid (outValid),
    .yOut     (yOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    h1 = '0; h2 = '0; expV = '0; lastY = '0;
    for (int i = 0; i < 3; i++) expY[i] = '0;
  endtask

  // One cycle: drive at negedge, update model at posedge, check at negedge.
  task automatic step(input logic v, input logic [31:0] x, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input string tag);
    logic [31:0] e;
    inValid = v; sampleIn = x; coefA = a; coefB = b; coefC = c;
    @(posedge clk);
    e = a * x + b * h1 + c * h2;
    expV[2] = expV[1]; expY[2] = expY[1];
    expV[1] = expV[0]; expY[1] = expY[0];
    expV[0] = v;       expY[0] = e;
    if (v) begin h2 = h1; h1 = x; end
    @(negedge clk);
    chk("R3 outValid", {31'b0, outValid}, {31'b0, expV[2]});
    if (expV[2]) begin
      chk(tag, yOut, expY[2]);
      lastY = expY[2];
    end else begin
      chk("R6 hold", yOut, lastY);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 32'hDEAD_0000 + i, coefA, coefB, coefC, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0;
    @(negedge clk);
    chk("R1 outValid in reset", {31'b0, outValid}, 32'd0);
    chk("R1 yOut in reset", yOut, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    modelClear();
    chk("R1 outValid after reset", {31'b0, outValid}, 32'd0);
    chk("R1 yOut after reset", yOut, 32'd0);
  endtask

  task automatic testImpulse();
    step(1'b1, 32'd1, 32'd3, 32'd5, 32'd7, "R7 impulse tap A");
    step(1'b1, 32'd0, 32'd3, 32'd5, 32'd7, "R7 impulse tap B");
    step(1'b1, 32'd0, 32'd3, 32'd5, 32'd7, "R7 impulse tap C");
    idle(3, "R7");
    chk("R7 last impulse result", lastY, 32'd7);
  endtask

  task automatic testBackToBack();
    for (int i = 0; i < 8; i++)
      step(1'b1, 32'd10 + i * 3, 32'd2, 32'hFFFF_FFFF, 32'd4, "R9 R2 streaming");
    idle(3, "R9");
  endtask

  task automatic testGaps();
    step(1'b1, 32'd100, 32'd1, 32'd10, 32'd100, "R4 gap sample");
    idle(2, "R4");
    step(1'b1, 32'd200, 32'd1, 32'd10, 32'd100, "R4 gap sample");
    idle(1, "R4");
    step(1'b1, 32'd300, 32'd1, 32'd10, 32'd100, "R4 gap sample");
    idle(3, "R4");
    chk("R4 history skips gaps", lastY, 32'd300 + 32'd2000 + 32'd10000);
  endtask

  task automatic testWrap();
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFF, "R5 wrap");
    step(1'b1, 32'h8000_0000, 32'h0000_0003, 32'hFFFF_FFFE, 32'h1234_5678, "R5 wrap");
    step(1'b1, 32'hC000_0000, 32'h0000_0004, 32'h0000_0002, 32'hFFFF_FFFF, "R5 wrap");
    idle(3, "R5");
  endtask

  task automatic testCoefTiming();
    step(1'b1, 32'd10, 32'd2, 32'd3, 32'd4, "R8 coef at accept");
    step(1'b0, 32'd55, 32'd100, 32'd200, 32'd300, "R8 coef at accept");
    step(1'b0, 32'd66, 32'd111, 32'd222, 32'd333, "R8 coef at accept");
    idle(2, "R8");
  endtask

  task automatic testMidReset();
    step(1'b1, 32'd9, 32'd1, 32'd1, 32'd1, "R2 before reset");
    step(1'b1, 32'd8, 32'd1, 32'd1, 32'd1, "R2 before reset");
    doReset();
    step(1'b1, 32'd5, 32'd6, 32'd7, 32'd8, "R1 history cleared");
    idle(3, "R1");
    chk("R1 first result after reset", lastY, 32'd30);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelClear();
    @(negedge clk);
    doReset();
    testImpulse();
    testBackToBack();
    testGaps();
    testWrap();
    testCoefTiming();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule